// File: doc/BRIEF.md
# Gated 22 kHz Tone Generator

This block produces the 22 kHz square-wave tone used for signalling to an outdoor unit over its supply line. The tone can run in two modes. In continuous mode it runs for as long as the section is powered and the tone path is armed. In gated mode an external envelope input, driven by a host microcontroller, switches the tone. The tone starts half a tone period after the envelope rises and keeps running for one full period after the envelope falls. Because of these delays, a burst-coded bit stream on the envelope gives whole tone cycles on the line.

The tone is only possible when the section is enabled and the tone path is armed. The arming is the OR of a control-register bit and a board pin. A separate active flag is high whenever the tone generator is running, including the stop tail. This flag can switch an external pull-down that discharges the output capacitance. The half period is computed at elaboration from the system clock and tone frequency parameters. The envelope input is asynchronous and passes through a configurable synchronizer.

Top module: `tone22k_gen`

## Requirements
- R1: With H = round(CLK_HZ / (2*TONE_HZ)) clock cycles, the tone is high for exactly H cycles and low for exactly H cycles in every period while it runs (period 2H).
- R2: While tx_arm_reg and tx_arm_pin are both 0, tone_out and tone_active stay 0. Clearing both while the tone runs forces both outputs to 0 from the clock after the change.
- R3: With pwr_en=1, the tone path armed and cont_mode=1, the tone starts within 3 cycles and runs without a gap, whatever env_in does; changing which arming source is used does not interrupt it.
- R4: In gated mode (cont_mode=0), the first high half starts H+1 to H+SYNC_STAGES+3 cycles after env_in rises, and it starts with a high level.
- R5: After env_in falls (or cont_mode is cleared while env_in is low), the tone keeps running for at least 2H cycles and has stopped no later than 3H+SYNC_STAGES+4 cycles after the fall.
- R6: While pwr_en=0 (standby), the tone function is disabled: tone_out and tone_active stay 0.
- R7: tone_active is 1 exactly while the generator runs, including the stop tail. It is 0 during the start delay and when idle, and tone_out is never 1 while tone_active is 0.
- R8: An envelope pulse of at most H-3 cycles produces no tone cycle and never sets tone_active.
- R9: A new rise of env_in during the stop tail cancels the stop: tone_active stays 1 and the waveform goes on without a gap.
- R10: Apart from the forced stops of R2 and R6, the tone always ends on a low level, so every high pulse lasts the full H cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Section enable; 0 is standby |
| tx_arm_reg | input | 1 | Tone-path arm from the control register |
| tx_arm_pin | input | 1 | Tone-path arm from the board pin |
| cont_mode | input | 1 | 1 selects a continuous tone, 0 selects envelope gating |
| env_in | input | 1 | Asynchronous tone envelope from the host |
| tone_out | output | 1 | Tone square wave |
| tone_active | output | 1 | High while the generator runs; drives the external pull-down |

## Verification
A wrong half-period count or a phase toggle at the wrong time shows at tone_out within one period, as a high or low stretch that is not exactly H cycles. A gating state that is stuck or skipped shows as a wrong start delay or tail length, measured from the envelope edge. It can also show as a tone from a pulse too short to start one, or as a gap when the envelope comes back during the tail. A wrong response to arming or enable shows on both outputs one clock after the input changes.

// File: rtl/tone22k_pkg.sv
package tone22k_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_ARM   = 3'd2,
      ST_RUN   = 3'd3,
      ST_TAIL  = 3'd4,
      ST_DRAIN = 3'd5
   } gate_st_t;

   // Half tone period in clock cycles, rounded to nearest.
   function automatic int half_cycles(input int clk_hz, input int tone_hz);
      return (clk_hz + tone_hz) / (2 * tone_hz);
   endfunction

endpackage

// File: rtl/tone22k_sync.sv
module tone22k_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else if (STAGES == 1) sr <= d_in;
            else sr <= {sr[STAGES-2:0], d_in};
         end
         assign d_out = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tone22k_wave.sv
module tone22k_wave #(
   parameter int HALF  = 50,
   parameter int CNT_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phase_hi,
   output logic tone
);
   localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         phase_hi <= 1'b1;
      end else if (!run) begin
         cnt      <= '0;
         phase_hi <= 1'b1;
      end else if (cnt == LIM_HALF) begin
         cnt      <= '0;
         phase_hi <= ~phase_hi;
      end else begin
         cnt      <= cnt + 1'b1;
      end
   end

   assign tone = run & phase_hi;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM_HALF); // R1

   AST_FULL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (phase_hi != $past(phase_hi))) |-> ($past(cnt) == LIM_HALF)); // R10
endmodule

// File: rtl/tone22k_gate.sv
module tone22k_gate
   import tone22k_pkg::*;
#(
   parameter int HALF  = 50,
   parameter int CNT_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic cont,
   input  logic env,
   input  logic phase_hi,
   output logic run
);
   localparam logic [CNT_W-1:0] LIM_ARM  = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] LIM_TAIL = CNT_W'(2 * HALF - 1);

   gate_st_t         st, st_nx;
   logic [CNT_W-1:0] dcnt, dcnt_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_OFF;
         dcnt <= '0;
      end else begin
         st   <= st_nx;
         dcnt <= dcnt_nx;
      end
   end

   always_comb begin
      st_nx   = st;
      dcnt_nx = dcnt;
      if (!allow) begin
         st_nx   = ST_OFF;
         dcnt_nx = '0;
      end else begin
         unique case (st)
            ST_OFF, ST_IDLE: begin
               dcnt_nx = '0;
               if (cont)     st_nx = ST_RUN;
               else if (env) st_nx = ST_ARM;
               else          st_nx = ST_IDLE;
            end
            ST_ARM: begin
               if (cont) begin
                  st_nx   = ST_RUN;
                  dcnt_nx = '0;
               end else if (!env) begin
                  st_nx   = ST_IDLE;
                  dcnt_nx = '0;
               end else if (dcnt == LIM_ARM) begin
                  st_nx   = ST_RUN;
                  dcnt_nx = '0;
               end else begin
                  dcnt_nx = dcnt + 1'b1;
               end
            end
            ST_RUN: begin
               dcnt_nx = '0;
               if (!cont && !env) st_nx = ST_TAIL;
            end
            ST_TAIL: begin
               if (cont || env) begin
                  st_nx   = ST_RUN;
                  dcnt_nx = '0;
               end else if (dcnt == LIM_TAIL) begin
                  st_nx   = ST_DRAIN;
                  dcnt_nx = '0;
               end else begin
                  dcnt_nx = dcnt + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (cont || env) st_nx = ST_RUN;
               else if (!phase_hi) st_nx = ST_IDLE;
            end
            default: begin
               st_nx   = ST_OFF;
               dcnt_nx = '0;
            end
         endcase
      end
   end

   assign run = (st == ST_RUN) || (st == ST_TAIL) || (st == ST_DRAIN);

   AST_NO_GATED_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_IDLE && st == ST_RUN) |-> $past(cont)); // R4

   AST_ARM_HAS_ENV: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_ARM && st == ST_RUN && !$past(cont)) |-> $past(env)); // R8
endmodule

// File: rtl/tone22k_gen.sv
module tone22k_gen #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int TONE_HZ     = 22_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic tx_arm_reg,
   input  logic tx_arm_pin,
   input  logic cont_mode,
   input  logic env_in,
   output logic tone_out,
   output logic tone_active
);
   import tone22k_pkg::*;

   localparam int HALF  = half_cycles(CLK_HZ, TONE_HZ);
   localparam int CNT_W = $clog2(2 * HALF);

   generate
      if (HALF < 2) begin : g_bad_ratio
         $error("tone22k_gen: clock too slow for the tone frequency");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tone22k_gen: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic allow, env_s, run, phase_hi;

   assign allow = pwr_en & (tx_arm_reg | tx_arm_pin);

   tone22k_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(env_in), .d_out(env_s)
   );

   tone22k_gate #(.HALF(HALF), .CNT_W(CNT_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .allow(allow), .cont(cont_mode),
      .env(env_s), .phase_hi(phase_hi), .run(run)
   );

   tone22k_wave #(.HALF(HALF), .CNT_W(CNT_W)) u_wave (
      .clk(clk), .rst_n(rst_n), .run(run), .phase_hi(phase_hi), .tone(tone_out)
   );

   assign tone_active = run;

   AST_OFF_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !allow |=> (!tone_out && !tone_active)); // R2

   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tone_active) |-> tone_out); // R4

   AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tone_active) && $past(allow)) |-> !$past(tone_out)); // R10
endmodule

// File: tb/tone22k_gen_bench.sv
module tone22k_gen_bench;
   localparam int CLK_HZ  = 2_200_000;
   localparam int TONE_HZ = 22_000;
   localparam int SYNC    = 2;

   function automatic int exp_half(input int c, input int t);
      return (c + t) / (2 * t);
   endfunction
   localparam int H = exp_half(CLK_HZ, TONE_HZ);

   // Does an envelope pulse of len cycles (from idle) start a tone?
   function automatic bit burst_makes_tone(input int len);
      return len >= H + 1;
   endfunction

   logic clk = 1'b0, rst_n = 1'b0;
   logic pwr_en = 0, tx_arm_reg = 0, tx_arm_pin = 0, cont_mode = 0, env_in = 0;
   logic tone_out, tone_active;

   int n_tests = 0, n_fail = 0;
   bit mon_en = 0;
   int hw = 0, lw = 0;

   always #5 clk = ~clk;

   tone22k_gen #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .SYNC_STAGES(SYNC)) u_tone22k_gen (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_arm_reg(tx_arm_reg),
      .tx_arm_pin(tx_arm_pin), .cont_mode(cont_mode), .env_in(env_in),
      .tone_out(tone_out), .tone_active(tone_active)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int which);
      return (which != 0) ? tone_active : tone_out;
   endfunction

   task automatic wait_for(input int which, input logic val, input int maxn, output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (sig(which) !== val && n < maxn);
   endtask

   // Count samples of a signal equal to val over n cycles.
   task automatic count_val(input int which, input logic val, input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (sig(which) === val) c++; end
   endtask

   // Width monitor: R1 and R10
   always @(negedge clk) begin
      if (!mon_en) begin
         hw = 0; lw = 0;
      end else begin
         if (tone_out && !tone_active) chk(0, "R7 tone without active", 1, 0);
         if (tone_out) begin
            if (lw > 0) chk(lw == H, "R1 low half width", lw, H);
            lw = 0;
            hw++;
         end else begin
            if (hw > 0) chk(hw == H, "R10 high pulse width", hw, H);
            hw = 0;
            if (tone_active) lw++; else lw = 0;
         end
      end
   end

   initial begin
      #(10 * 200_000);
      chk(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int n, a, b, c;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      chk(tone_out == 0 && tone_active == 0, "reset state R7", {tone_out, tone_active}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: not armed, everything else asking for tone
      pwr_en = 1; cont_mode = 1; env_in = 1;
      count_val(0, 1'b1, 4 * H, c);
      chk(c == 0, "R2 tone while disarmed", c, 0);
      count_val(1, 1'b1, H, c);
      chk(c == 0, "R2 active while disarmed", c, 0);
      env_in = 0;

      // R3: continuous via pin
      mon_en = 1;
      tx_arm_pin = 1;
      wait_for(0, 1'b1, 20, n);
      chk(n <= 3, "R3 continuous start delay", n, 3);
      wait_for(0, 1'b0, 3 * H, a);
      wait_for(0, 1'b1, 3 * H, b);
      chk(a + b == 2 * H, "R1 period", a + b, 2 * H);
      c = 0;
      for (int i = 0; i < 8; i++) begin
         env_in = ~env_in;
         repeat (H / 2) begin @(negedge clk); if (!tone_active) c++; end
      end
      env_in = 0;
      chk(c == 0, "R3 gap with envelope toggling", c, 0);
      tx_arm_reg = 1; @(negedge clk); tx_arm_pin = 0;
      count_val(1, 1'b0, 3 * H, c);
      chk(c == 0, "R3 arm source swap gap", c, 0);

      // R5: cont cleared with envelope low -> tail
      cont_mode = 0;
      wait_for(1, 1'b0, 5 * H, n);
      chk(n >= 2 * H && n <= 3 * H + 4, "R5 tail after continuous", n, 2 * H);

      // R6: standby
      cont_mode = 1; mon_en = 0; pwr_en = 0;
      count_val(1, 1'b1, 3 * H, c);
      chk(c == 0, "R6 active in standby", c, 0);
      pwr_en = 1;
      wait_for(0, 1'b1, 20, n);
      chk(n <= 3, "R3 restart after standby", n, 3);
      repeat (H / 3) @(negedge clk);
      pwr_en = 0;
      repeat (2) @(negedge clk);
      chk(tone_out == 0 && tone_active == 0, "R6 forced off", {tone_out, tone_active}, 0);
      pwr_en = 1;
      repeat (H / 2) @(negedge clk);

      // R2: drop arming while running
      tx_arm_reg = 0;
      repeat (2) @(negedge clk);
      chk(tone_out == 0 && tone_active == 0, "R2 forced off", {tone_out, tone_active}, 0);

      // gated mode
      cont_mode = 0; tx_arm_reg = 1;
      repeat (4) @(negedge clk);
      mon_en = 1;
      env_in = 1;
      n = 0;
      do begin
         @(negedge clk); n++;
         if (n == H / 2) chk(tone_active == 0, "R7 active during start delay", tone_active, 0);
      end while (!tone_out && n < 4 * H);
      chk(n >= H + 1 && n <= H + SYNC + 3, "R4 gated start delay", n, H + SYNC + 1);
      repeat (3 * H) @(negedge clk);
      env_in = 0;
      wait_for(1, 1'b0, 5 * H, n);
      chk(n >= 2 * H && n <= 3 * H + SYNC + 4, "R5 gated tail", n, 2 * H);
      repeat (3) @(negedge clk);
      chk(tone_active == 0, "R7 idle after tail", tone_active, 0);

      // R8: short pulse
      env_in = 1; repeat (H / 2) @(negedge clk); env_in = 0;
      count_val(1, 1'b1, 3 * H, c);
      chk(c == 0, "R8 short pulse active", c, 0);
      env_in = 1; repeat (H - 3) @(negedge clk); env_in = 0;
      count_val(1, 1'b1, 3 * H, c);
      chk(c == 0, "R8 pulse at limit", c, 0);

      // R9: re-rise during tail
      env_in = 1;
      wait_for(0, 1'b1, 4 * H, n);
      repeat (2 * H) @(negedge clk);
      env_in = 0;
      c = 0;
      repeat (H) begin @(negedge clk); if (!tone_active) c++; end
      env_in = 1;
      a = 0;
      repeat (3 * H) begin @(negedge clk); if (!tone_active) c++; if (tone_out) a++; end
      chk(c == 0, "R9 gap on re-rise", c, 0);
      chk(a > 0, "R9 tone continues", a, 1);
      env_in = 0;
      wait_for(1, 1'b0, 5 * H, n);
      chk(tone_active == 0, "R5 stop after cancel", tone_active, 0);

      // random bursts
      for (int k = 0; k < 24; k++) begin
         int len;
         bit seen;
         len = ($urandom_range(0, 2) == 0) ? int'($urandom_range(2, H - 3))
                                           : int'($urandom_range(H + 4, 6 * H));
         seen = 0;
         env_in = 1;
         repeat (len) begin @(negedge clk); if (tone_active) seen = 1; end
         env_in = 0;
         repeat (4) begin @(negedge clk); if (tone_active) seen = 1; end
         chk(seen == burst_makes_tone(len), "R8 random burst tone", seen, burst_makes_tone(len));
         wait_for(1, 1'b0, 5 * H, n);
         chk(tone_active == 0, "R5 random burst stop", tone_active, 0);
         repeat ($urandom_range(1, H)) @(negedge clk);
      end

      mon_en = 0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule